// File: doc/BRIEF.md
# Processor Control and Status Register

This block holds the 32-bit control and status word of a DSP-style processor core. The word combines a fixed identity half-word, a power-down command field that is never stored for read-back, a sticky saturation flag, a fixed byte-order indicator, two cache mode selectors and the global interrupt enable together with its saved copy.

Software changes the word through a move-to-control write port. That port carries a condition qualifier: when the qualifier is false, the write is dropped as a whole. Functional units raise single-cycle saturation pulses. The interrupt logic signals when an interrupt is taken and when a handler returns, so the enable state is saved and restored across nested interrupts.

A power-down command puts the block into an encoded low-power state. The block leaves that state when the wake condition chosen by the command becomes true.

Top module: `csr_ctrl_status`

## Requirements
- R1: Bits 31:16 of `rd_data` always read 16'h0203. The upper byte is the core identity and the lower byte is the revision.
- R2: Bit 8 of `rd_data` is the byte-order indicator. It is read-only and comes from parameter `LITTLE_END`, where 1 means little endian and is the default. Bits 15:10 of `rd_data` always read zero.
- R3: A saturation pulse on any bit of `sat_evt` in cycle c sets bit 9 (the saturation flag). The flag is not visible after the edge that closes cycle c; it becomes visible after the following edge.
- R4: A write cannot set the saturation flag. An accepted write with `wr_data[9]`=0 clears it. If a delayed set and a clear land on the same edge, the set wins.
- R5: A write is accepted only when `wr_en` and `wr_cond` are both 1. If `wr_cond` is 0, no field changes: not the flag, not the cache modes, not the enables and not the power state.
- R6: The program cache mode (bits 7:5, from `wr_data[7:5]`) and the data cache mode (bits 4:2, from `wr_data[4:2]`) take codes 3'b000 or 3'b010 from an accepted write.
- R7: An accepted write that carries any other cache code leaves that cache field at its previous value.
- R8: A synchronous reset `rst` clears the saturation flag, both cache modes, the global enable (bit 0) and the saved enable (bit 1). It also returns `pd_state` to 0 (running).
- R9: On `irq_taken`, the saved enable takes the current global enable and the global enable goes to 0, both on the same edge. This has priority over `irq_return` and over a write in the same cycle.
- R10: On `irq_return` without `irq_taken`, the global enable is restored from the saved enable. This has priority over a write.
- R11: An accepted write while running decodes `wr_data[15:10]` as follows: 6'b001001 gives `pd_state`=1, 6'b010001 gives 2, 6'b011010 gives 3 and 6'b011100 gives 4. The code 000000 and all reserved codes keep `pd_state` at 0. Power-down codes written while not running are ignored.
- R12: In state 1, the block returns to 0 only when `pend_enabled` is 1 and the global enable is 1.
- R13: In state 2, the block returns to 0 when `pend_enabled` or `pend_any` is 1.
- R14: In states 3 and 4, only `pend_reset` (or `rst`) returns the block to 0. Other pending inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| wr_en | input | 1 | Move-to-control write strobe |
| wr_cond | input | 1 | Condition qualifier of the write |
| wr_data | input | 32 | Write data |
| sat_evt | input | N_UNITS | Saturation pulses, one per functional unit |
| irq_taken | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Interrupt return strobe |
| pend_enabled | input | 1 | An enabled interrupt is pending |
| pend_any | input | 1 | Some interrupt is pending, enabled or not |
| pend_reset | input | 1 | A reset wake request is pending |
| pd_state | output | 3 | Power state: 0 run, 1/2 light sleep, 3/4 deep sleep |
| rd_data | output | 32 | Current register read value |

## Verification
The main same-cycle conflict is between the delayed saturation set and a software clear of the flag. The bench provokes it by pulsing `sat_evt` and then issuing a clearing write in the next cycle, so both reach the flag on the same edge. It judges the result by the flag being 1 afterwards, and by a second, lone clear then removing the flag. A second conflict is an interrupt entry coinciding with a write of the enable bits. Here the saved and global enables must follow the interrupt and not the write data.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int XLEN     = 32;
    localparam int PD_W     = 6;
    localparam int CM_W     = 3;
    localparam int PD_LSB   = 10;
    localparam int SAT_BIT  = 9;
    localparam int PCC_LSB  = 5;
    localparam int DCC_LSB  = 2;
    localparam int PGIE_BIT = 1;
    localparam int GIE_BIT  = 0;
    localparam int N_CACHE  = 2;
    localparam logic [15:0] ID_WORD = 16'h0203;

    typedef enum logic [2:0] {
        PS_RUN     = 3'd0,
        PS_PD1_EN  = 3'd1,
        PS_PD1_ANY = 3'd2,
        PS_PD2     = 3'd3,
        PS_PD3     = 3'd4
    } pd_state_e;

    typedef struct packed {
        logic [PD_W-1:0] pd;
        logic            sat;
        logic            endian;
        logic [CM_W-1:0] pcc;
        logic [CM_W-1:0] dcc;
        logic            pgie;
        logic            gie;
    } csr_low_t;

    typedef struct packed {
        logic      hit;
        pd_state_e st;
    } pd_dec_t;

    function automatic pd_dec_t decode_pd(input logic [PD_W-1:0] code);
        pd_dec_t d;
        d.hit = 1'b1;
        case (code)
            6'b001001: d.st = PS_PD1_EN;
            6'b010001: d.st = PS_PD1_ANY;
            6'b011010: d.st = PS_PD2;
            6'b011100: d.st = PS_PD3;
            default: begin
                d.hit = 1'b0;
                d.st  = PS_RUN;
            end
        endcase
        return d;
    endfunction

    function automatic logic cache_code_ok(input logic [CM_W-1:0] c);
        return (c == 3'b000) || (c == 3'b010);
    endfunction

endpackage

// File: rtl/csr_sat_flag.sv
module csr_sat_flag
    import csr_pkg::*;
#(
    parameter int N_UNITS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_UNITS-1:0] sat_evt,
    input  logic               clr_req,
    output logic               sat_o
);
    logic set_dly;
    logic sat_q;

    // the event is registered once, then lands on the flag one edge later
    always_ff @(posedge clk) begin
        if (rst) begin
            set_dly <= 1'b0;
            sat_q   <= 1'b0;
        end else begin
            set_dly <= |sat_evt;
            if (set_dly)
                sat_q <= 1'b1;
            else if (clr_req)
                sat_q <= 1'b0;
        end
    end

    assign sat_o = sat_q;

    AST_SAT_DELAYED_SET: assert property (@(posedge clk) disable iff (rst)
        (|sat_evt) |=> ##1 sat_q); // R3
    AST_SAT_NO_SOFT_SET: assert property (@(posedge clk) disable iff (rst)
        (!sat_q && !set_dly) |=> !sat_q); // R4
    AST_SAT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_dly && clr_req) |=> sat_q); // R4

endmodule

// File: rtl/csr_cache_field.sv
module csr_cache_field
    import csr_pkg::*;
#(
    parameter int W = CM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_acc,
    input  logic [W-1:0] code_in,
    output logic [W-1:0] code_o
);
    logic [W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (wr_acc && cache_code_ok(code_in))
            code_q <= code_in;
    end

    assign code_o = code_q;

    AST_CACHE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (code_q == 3'b000) || (code_q == 3'b010)); // R7

endmodule

// File: rtl/csr_int_enable.sv
module csr_int_enable
    import csr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irq_taken,
    input  logic irq_return,
    input  logic wr_acc,
    input  logic wr_gie,
    input  logic wr_pgie,
    output logic gie_o,
    output logic pgie_o
);
    logic gie_q;
    logic pgie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q  <= 1'b0;
            pgie_q <= 1'b0;
        end else if (irq_taken) begin
            pgie_q <= gie_q;
            gie_q  <= 1'b0;
        end else if (irq_return) begin
            gie_q  <= pgie_q;
        end else if (wr_acc) begin
            gie_q  <= wr_gie;
            pgie_q <= wr_pgie;
        end
    end

    assign gie_o  = gie_q;
    assign pgie_o = pgie_q;

    AST_TAKEN_SAVES: assert property (@(posedge clk) disable iff (rst)
        irq_taken |=> (!gie_q && (pgie_q == $past(gie_q)))); // R9
    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (irq_return && !irq_taken) |=> (gie_q == $past(pgie_q))); // R10

endmodule

// File: rtl/csr_pdn_ctrl.sv
module csr_pdn_ctrl
    import csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_acc,
    input  logic [PD_W-1:0] code_in,
    input  logic            gie,
    input  logic            pend_enabled,
    input  logic            pend_any,
    input  logic            pend_reset,
    output pd_state_e       state_o
);
    pd_state_e st_q, st_d;
    pd_dec_t   dec;

    always_comb begin
        dec  = decode_pd(code_in);
        st_d = st_q;
        case (st_q)
            PS_RUN:     if (wr_acc && dec.hit) st_d = dec.st;
            PS_PD1_EN:  if (pend_enabled && gie) st_d = PS_RUN;
            PS_PD1_ANY: if (pend_enabled || pend_any) st_d = PS_RUN;
            PS_PD2,
            PS_PD3:     if (pend_reset) st_d = PS_RUN;
            default:    st_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= PS_RUN;
        else
            st_q <= st_d;
    end

    assign state_o = st_q;

    AST_PD1_ENABLED_WAKE: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_PD1_EN && pend_enabled && gie) |=> (st_q == PS_RUN)); // R12
    AST_PD1_MASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_PD1_EN && !gie) |=> (st_q == PS_PD1_EN)); // R12
    AST_PD1_ANY_WAKE: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_PD1_ANY && pend_any) |=> (st_q == PS_RUN)); // R13
    AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((st_q == PS_PD2 || st_q == PS_PD3) && !pend_reset) |=> $stable(st_q)); // R14

endmodule

// File: rtl/csr_ctrl_status.sv
module csr_ctrl_status
    import csr_pkg::*;
#(
    parameter int   N_UNITS    = 4,
    parameter logic LITTLE_END = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_cond,
    input  logic [31:0]        wr_data,
    input  logic [N_UNITS-1:0] sat_evt,
    input  logic               irq_taken,
    input  logic               irq_return,
    input  logic               pend_enabled,
    input  logic               pend_any,
    input  logic               pend_reset,
    output logic [2:0]         pd_state,
    output logic [31:0]        rd_data
);
    localparam int CACHE_LSB [N_CACHE] = '{PCC_LSB, DCC_LSB};

    logic            wr_acc;
    logic            sat;
    logic            gie;
    logic            pgie;
    logic [CM_W-1:0] cm [N_CACHE];
    pd_state_e       pst;
    csr_low_t        low;
    logic            unused_bits;

    assign wr_acc      = wr_en && wr_cond;
    assign unused_bits = ^{wr_data[31:16], wr_data[8]};

    csr_sat_flag #(.N_UNITS(N_UNITS)) u_sat (
        .clk     (clk),
        .rst     (rst),
        .sat_evt (sat_evt),
        .clr_req (wr_acc && !wr_data[SAT_BIT]),
        .sat_o   (sat)
    );

    for (genvar i = 0; i < N_CACHE; i++) begin : g_cache
        csr_cache_field #(.W(CM_W)) u_cf (
            .clk     (clk),
            .rst     (rst),
            .wr_acc  (wr_acc),
            .code_in (wr_data[CACHE_LSB[i] +: CM_W]),
            .code_o  (cm[i])
        );
    end

    csr_int_enable u_ie (
        .clk        (clk),
        .rst        (rst),
        .irq_taken  (irq_taken),
        .irq_return (irq_return),
        .wr_acc     (wr_acc),
        .wr_gie     (wr_data[GIE_BIT]),
        .wr_pgie    (wr_data[PGIE_BIT]),
        .gie_o      (gie),
        .pgie_o     (pgie)
    );

    csr_pdn_ctrl u_pd (
        .clk          (clk),
        .rst          (rst),
        .wr_acc       (wr_acc),
        .code_in      (wr_data[PD_LSB +: PD_W]),
        .gie          (gie),
        .pend_enabled (pend_enabled),
        .pend_any     (pend_any),
        .pend_reset   (pend_reset),
        .state_o      (pst)
    );

    always_comb begin
        low.pd     = '0;
        low.sat    = sat;
        low.endian = LITTLE_END;
        low.pcc    = cm[0];
        low.dcc    = cm[1];
        low.pgie   = pgie;
        low.gie    = gie;
    end

    assign rd_data  = {ID_WORD, low};
    assign pd_state = pst;

    AST_COND_FALSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_cond) |=> ($stable(cm[0]) && $stable(cm[1]))); // R5
    AST_COND_FALSE_NO_PD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_cond && pst == PS_RUN) |=> (pst == PS_RUN)); // R5

endmodule

// File: tb/sim_csr_ctrl_status.sv
module sim_csr_ctrl_status;

    typedef struct {
        int          due;
        logic [31:0] rd;
        logic [2:0]  pd;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_cond = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  sat_evt = '0;
    logic        irq_taken = 1'b0, irq_return = 1'b0;
    logic        pend_enabled = 1'b0, pend_any = 1'b0, pend_reset = 1'b0;
    logic [2:0]  pd_state;
    logic [31:0] rd_data;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t q[$];

    always #5 clk = ~clk;

    csr_ctrl_status u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cond(wr_cond), .wr_data(wr_data),
        .sat_evt(sat_evt), .irq_taken(irq_taken), .irq_return(irq_return),
        .pend_enabled(pend_enabled), .pend_any(pend_any), .pend_reset(pend_reset),
        .pd_state(pd_state), .rd_data(rd_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops due items and compares at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (rd_data !== it.rd || pd_state !== it.pd) begin
                errors++;
                $display("FAIL %s: rd=%h pd=%0d expected rd=%h pd=%0d",
                         it.tag, rd_data, pd_state, it.rd, it.pd);
            end
        end
    end

    function automatic logic [31:0] mk(logic s, logic [2:0] pc, logic [2:0] dc, logic pg, logic g);
        return {16'h0203, 6'b0, s, 1'b1, pc, dc, pg, g};
    endfunction

    function automatic logic [31:0] wd(logic [5:0] p, logic s, logic [2:0] pc, logic [2:0] dc,
                                       logic pg, logic g);
        return {16'h0, p, s, 1'b0, pc, dc, pg, g};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(int k, logic [31:0] rd, logic [2:0] pd, string tag);
        item_t it;
        it.due = cyc + k; it.rd = rd; it.pd = pd; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(logic [31:0] d, logic c, logic [31:0] erd, logic [2:0] epd, string tag);
        wr_en = 1'b1; wr_cond = c; wr_data = d;
        expect_at(1, erd, epd, tag);
        tick();
        wr_en = 1'b0; wr_cond = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        expect_at(0, mk(0, 0, 0, 0, 0), 3'd0, "R8 R1 R2 reset");
        tick();

        wr(wd(0, 1, 3'd2, 3'd2, 0, 1), 1, mk(0, 2, 2, 0, 1), 0, "R6 R4 write no sat set");
        wr(wd(0, 0, 3'd3, 3'd5, 0, 1), 1, mk(0, 2, 2, 0, 1), 0, "R7 reserved cache");
        wr(wd(0, 0, 3'd0, 3'd0, 1, 0), 0, mk(0, 2, 2, 0, 1), 0, "R5 cond false fields");
        wr(wd(6'b001001, 0, 3'd2, 3'd2, 0, 1), 0, mk(0, 2, 2, 0, 1), 0, "R5 cond false pd");

        // R3 delayed set
        sat_evt = 4'b0100;
        expect_at(1, mk(0, 2, 2, 0, 1), 0, "R3 not yet set");
        tick();
        sat_evt = '0;
        expect_at(1, mk(1, 2, 2, 0, 1), 0, "R3 set after delay");
        tick();

        wr(wd(0, 0, 3'd2, 3'd2, 0, 1), 0, mk(1, 2, 2, 0, 1), 0, "R5 cond false keeps sat");
        wr(wd(0, 0, 3'd2, 3'd2, 0, 1), 1, mk(0, 2, 2, 0, 1), 0, "R4 soft clear");

        // R4 collision: delayed set meets clear on same edge
        sat_evt = 4'b0001;
        expect_at(1, mk(0, 2, 2, 0, 1), 0, "R3 pending");
        tick();
        sat_evt = '0;
        wr(wd(0, 0, 3'd2, 3'd2, 0, 1), 1, mk(1, 2, 2, 0, 1), 0, "R4 set beats clear");
        wr(wd(0, 0, 3'd2, 3'd2, 0, 1), 1, mk(0, 2, 2, 0, 1), 0, "R4 lone clear");

        // interrupts
        irq_taken = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 0), 0, "R9 taken");
        tick();
        irq_taken = 1'b0;
        irq_return = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 1), 0, "R10 return");
        tick();
        irq_return = 1'b0;
        irq_taken = 1'b1;
        wr(wd(0, 0, 3'd2, 3'd2, 0, 1), 1, mk(0, 2, 2, 1, 0), 0, "R9 taken beats write");
        irq_taken = 1'b0;

        // R12: PD1 masked by global enable
        wr(wd(6'b001001, 0, 3'd2, 3'd2, 1, 0), 1, mk(0, 2, 2, 1, 0), 3'd1, "R11 R2 enter pd1");
        pend_any = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 0), 3'd1, "R12 any ignored");
        tick();
        pend_any = 1'b0;
        pend_enabled = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 0), 3'd1, "R12 masked by gie");
        tick();
        pend_enabled = 1'b0;
        irq_return = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 1), 3'd1, "R10 restore in pd1");
        tick();
        irq_return = 1'b0;
        pend_enabled = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 1), 3'd0, "R12 wake");
        tick();
        pend_enabled = 1'b0;

        // R13
        wr(wd(6'b010001, 0, 3'd2, 3'd2, 1, 1), 1, mk(0, 2, 2, 1, 1), 3'd2, "R11 enter pd1 any");
        wr(wd(6'b011010, 0, 3'd2, 3'd2, 1, 1), 1, mk(0, 2, 2, 1, 1), 3'd2, "R11 write while asleep");
        pend_any = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 1), 3'd0, "R13 wake any");
        tick();
        pend_any = 1'b0;

        // R14
        wr(wd(6'b011010, 0, 3'd2, 3'd2, 1, 1), 1, mk(0, 2, 2, 1, 1), 3'd3, "R11 enter pd2");
        pend_enabled = 1'b1; pend_any = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 1), 3'd3, "R14 pd2 holds");
        tick();
        pend_enabled = 1'b0; pend_any = 1'b0;
        pend_reset = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 1), 3'd0, "R14 pd2 reset wake");
        tick();
        pend_reset = 1'b0;
        wr(wd(6'b000111, 0, 3'd2, 3'd2, 1, 1), 1, mk(0, 2, 2, 1, 1), 3'd0, "R11 reserved pd code");
        wr(wd(6'b011100, 0, 3'd2, 3'd2, 1, 1), 1, mk(0, 2, 2, 1, 1), 3'd4, "R11 enter pd3");
        pend_reset = 1'b1;
        expect_at(1, mk(0, 2, 2, 1, 1), 3'd0, "R14 pd3 reset wake");
        tick();
        pend_reset = 1'b0;
        wr(wd(6'b011100, 0, 3'd2, 3'd2, 1, 1), 1, mk(0, 2, 2, 1, 1), 3'd4, "R11 enter pd3 again");
        sat_evt = 4'b1000;
        tick();
        sat_evt = '0;
        rst = 1'b1;
        expect_at(1, mk(0, 0, 0, 0, 0), 3'd0, "R8 device reset");
        tick();
        rst = 1'b0;
        expect_at(1, mk(0, 0, 0, 0, 0), 3'd0, "R8 R3 no late sat after reset");
        tick();

        tick();
        tick();
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R1: %0d expected items left, expected 0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired, actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule